// File: doc/BRIEF.md
# Clause 22 Management Bus Master

This block is a serial management master for Ethernet PHYs. It turns one request into one Clause 22 read or write frame on a shared two-wire management bus. The bus has a clock (MDC) made by a divider from the system clock, and a single open-drain data line. Several PHYs may share the line, and each PHY is selected by its 5-bit address inside the frame.

A request is offered with a valid/ready handshake. It carries the direction, the PHY address, the register address, the write data and a flag that shortens the preamble. The flag exists because some PHYs on a shared bus accept a shortened preamble and others do not, so the choice is made per frame. The line is never driven high. The data output pin stays at 0, and a 1 on the bus comes from releasing the tristate enable and letting the external pull-up act. When the frame ends, a response with the captured read data is shown for exactly one cycle. Nothing on the response side can stall it.

MDC, the data output and the tristate enable each come directly from a flip-flop, so pad registers or buffers outside the block can take them unchanged.

Top module: `mdio_master`

## Requirements
- R1: `req_ready` is 1 exactly while the master is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. From that edge until the response, `req_ready` stays 0 and no further request is taken.
- R2: MDC is 0 while idle. During a frame, each MDC half-period lasts H system clocks. H is `div_half` sampled at acceptance, and any value below 2 is used as 2. The response appears exactly 2·H·(P+32) cycles after the accepting edge, where P is the preamble length.
- R3: The preamble is P released bits (logic 1). P is 32 when `req_short_pre`=0 and 1 when `req_short_pre`=1.
- R4: After the preamble, the bits on the line, in order, are: start 0 then 1; opcode 1,0 for a read (`req_read`=1) or 0,1 for a write; the PHY address MSB first; the register address MSB first.
- R5: On a write, the turnaround is driven as 1 then 0, and then `req_wdata` is sent MSB first.
- R6: On a read, the master releases the line for both turnaround bits and all 16 data bits. It samples the line at each MDC rising edge of the data bits, MSB first, and returns the result on `rsp_rdata`. A write response carries `rsp_rdata`=0.
- R7: `mdio_o` is always 0. The line is pulled low only through `mdio_oe`=1, and `mdio_oe` changes only on edges after which MDC is 0.
- R8: `rsp_valid` is a single-cycle pulse. It occurs on the edge where the master returns to idle with MDC low.
- R9: Asserting `req_valid` while a frame is in progress has no effect on that frame's bits or its response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_half | input | DIV_W | MDC half-period in system clocks (values below 2 act as 2) |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Master idle, request can be taken |
| req_read | input | 1 | 1 = read frame, 0 = write frame |
| req_short_pre | input | 1 | 1 = one-bit preamble, 0 = 32-bit preamble |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data (0 after a write) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data output pin, always 0 |
| mdio_oe | output | 1 | Output enable: 1 pulls the line low |
| mdio_i | input | 1 | Line value as seen at the pad |

## Verification
The assertions take for granted that the request fields hold steady while `req_valid` is 1 and that `mdio_i` is the resolved line value, so a PHY drives it only in the read turnaround and data windows. The bench models the pull-up and a PHY that drives the line only at MDC falling edges inside those windows, so there is never contention with `mdio_oe`. Divider settings stay small, with 0 and 1 included to reach the clamp. Extra requests are raised only while a frame is already in progress.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int unsigned ADDR_W     = 5;
  localparam int unsigned DATA_W     = 16;
  localparam int unsigned FRAME_W    = 32;
  localparam int unsigned PRE_FULL   = 32;
  localparam int unsigned BIT_CNT_W  = $clog2(FRAME_W);
  localparam int unsigned PRE_CNT_W  = $clog2(PRE_FULL);

  localparam logic [1:0] SOF_BITS   = 2'b01;
  localparam logic [1:0] OPC_READ   = 2'b10;
  localparam logic [1:0] OPC_WRITE  = 2'b01;
  localparam logic [1:0] TURN_WRITE = 2'b10;
  localparam logic [1:0] TURN_READ  = 2'b11;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_PRE   = 2'd1,
    SEQ_FRAME = 2'd2
  } seq_state_e;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_half,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);
  localparam logic [DIV_W-1:0] DIV_MIN = DIV_W'(2);

  logic [DIV_W-1:0] div_q, div_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             mdc_q, mdc_d;
  logic             cnt_end;

  assign cnt_end = (cnt_q == div_q - DIV_W'(1));

  always_comb begin
    div_d = div_q;
    if (!run) begin
      div_d = (div_half < DIV_MIN) ? DIV_MIN : div_half;
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (cnt_end) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= DIV_MIN;
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      div_q <= div_d;
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc       = mdc_q;
  assign rise_tick = run & cnt_end & ~mdc_q;
  assign fall_tick = run & cnt_end &  mdc_q;
endmodule

// File: rtl/mdio_frame_pack.sv
module mdio_frame_pack
  import mdio_pkg::*;
(
  input  logic              is_read,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [FRAME_W-1:0] frame
);
  logic [1:0]        opc;
  logic [1:0]        turn;
  logic [DATA_W-1:0] payload;

  always_comb begin
    if (is_read) begin
      opc     = OPC_READ;
      turn    = TURN_READ;
      payload = '1;
    end else begin
      opc     = OPC_WRITE;
      turn    = TURN_WRITE;
      payload = wdata;
    end
    frame = {SOF_BITS, opc, phy_addr, reg_addr, turn, payload};
  end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_read,
  input  logic               req_short_pre,
  input  logic [FRAME_W-1:0] req_frame,
  input  logic               rise_tick,
  input  logic               fall_tick,
  input  logic               line_in,
  output logic               req_ready,
  output logic               run,
  output logic               pin_oe,
  output logic               pin_out,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_rdata
);
  localparam logic [PRE_CNT_W-1:0] PRE_LAST = PRE_CNT_W'(PRE_FULL - 1);
  localparam logic [BIT_CNT_W-1:0] BIT_LAST = BIT_CNT_W'(FRAME_W - 1);
  localparam logic [BIT_CNT_W-1:0] DATA_FIRST = BIT_CNT_W'(FRAME_W - DATA_W);

  seq_state_e             st_q, st_d;
  logic [FRAME_W-1:0]     sh_q, sh_d;
  logic [PRE_CNT_W-1:0]   pre_q, pre_d;
  logic [BIT_CNT_W-1:0]   bit_q, bit_d;
  logic                   rd_q, rd_d;
  logic                   oe_q, oe_d;
  logic                   rv_q, rv_d;
  logic [DATA_W-1:0]      rdat_q, rdat_d;
  logic                   out_q;

  always_comb begin
    st_d   = st_q;
    sh_d   = sh_q;
    pre_d  = pre_q;
    bit_d  = bit_q;
    rd_d   = rd_q;
    oe_d   = oe_q;
    rv_d   = 1'b0;
    rdat_d = rdat_q;
    unique case (st_q)
      SEQ_IDLE: begin
        if (req_valid) begin
          st_d   = SEQ_PRE;
          sh_d   = req_frame;
          rd_d   = req_read;
          pre_d  = req_short_pre ? '0 : PRE_LAST;
          bit_d  = '0;
          oe_d   = 1'b0;
          rdat_d = '0;
        end
      end
      SEQ_PRE: begin
        if (fall_tick) begin
          if (pre_q == '0) begin
            st_d = SEQ_FRAME;
            oe_d = ~sh_q[FRAME_W-1];
          end else begin
            pre_d = pre_q - PRE_CNT_W'(1);
            oe_d  = 1'b0;
          end
        end
      end
      SEQ_FRAME: begin
        if (rise_tick && rd_q && (bit_q >= DATA_FIRST)) begin
          rdat_d = {rdat_q[DATA_W-2:0], line_in};
        end
        if (fall_tick) begin
          if (bit_q == BIT_LAST) begin
            st_d = SEQ_IDLE;
            oe_d = 1'b0;
            rv_d = 1'b1;
          end else begin
            bit_d = bit_q + BIT_CNT_W'(1);
            sh_d  = {sh_q[FRAME_W-2:0], 1'b1};
            oe_d  = ~sh_q[FRAME_W-2];
          end
        end
      end
      default: begin
        st_d = SEQ_IDLE;
        oe_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      sh_q   <= '1;
      pre_q  <= '0;
      bit_q  <= '0;
      rd_q   <= 1'b0;
      oe_q   <= 1'b0;
      rv_q   <= 1'b0;
      rdat_q <= '0;
      out_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      sh_q   <= sh_d;
      pre_q  <= pre_d;
      bit_q  <= bit_d;
      rd_q   <= rd_d;
      oe_q   <= oe_d;
      rv_q   <= rv_d;
      rdat_q <= rdat_d;
      out_q  <= 1'b0;
    end
  end

  assign req_ready = (st_q == SEQ_IDLE);
  assign run       = (st_q != SEQ_IDLE);
  assign pin_oe    = oe_q;
  assign pin_out   = out_q;
  assign rsp_valid = rv_q;
  assign rsp_rdata = rdat_q;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div_half,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_read,
  input  logic              req_short_pre,
  input  logic [4:0]        req_phy,
  input  logic [4:0]        req_reg,
  input  logic [15:0]       req_wdata,
  output logic              rsp_valid,
  output logic [15:0]       rsp_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic [FRAME_W-1:0] packed_frame;
  logic               run;
  logic               rise_tick;
  logic               fall_tick;

  mdio_frame_pack u_pack (
    .is_read  (req_read),
    .phy_addr (req_phy),
    .reg_addr (req_reg),
    .wdata    (req_wdata),
    .frame    (packed_frame)
  );

  mdio_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .div_half  (div_half),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mdio_frame_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_read      (req_read),
    .req_short_pre (req_short_pre),
    .req_frame     (packed_frame),
    .rise_tick     (rise_tick),
    .fall_tick     (fall_tick),
    .line_in       (mdio_i),
    .req_ready     (req_ready),
    .run           (run),
    .pin_oe        (mdio_oe),
    .pin_out       (mdio_o),
    .rsp_valid     (rsp_valid),
    .rsp_rdata     (rsp_rdata)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic clk,
  input logic rst_n,
  input logic mdc,
  input logic mdio_oe,
  input logic req_valid,
  input logic req_ready,
  input logic rsp_valid
);
  assert_oe_moves_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_oe) |-> !mdc);

  assert_busy_while_mdc_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> !req_ready);

  assert_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_rsp_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_rsp_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (req_ready && !mdc));

  assert_mdc_high_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |=> mdc);

  assert_mdc_low_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mdc) |=> !mdc);
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mdc       (mdc),
  .mdio_oe   (mdio_oe),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid)
);

// File: tb/mdio_master_test.sv
module mdio_master_test;
  logic        clk;
  logic        rst_n;
  logic [7:0]  div_half;
  logic        req_valid;
  logic        req_ready;
  logic        req_read;
  logic        req_short_pre;
  logic [4:0]  req_phy;
  logic [4:0]  req_reg;
  logic [15:0] req_wdata;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        mdc;
  logic        mdio_o;
  logic        mdio_oe;
  logic        mdio_i;

  int unsigned n_tests = 0;
  int unsigned n_fail  = 0;
  int unsigned cyc     = 0;
  bit          done    = 0;

  // PHY and line model
  bit          cur_read;
  int          cur_pre;
  logic [15:0] cur_val;
  int          seen;
  logic [63:0] cap;
  int          oe_bad;
  int          mdo_bad;
  int          oe_hi_bad;
  logic        phy_en;
  logic        phy_bit;
  logic        prev_oe;

  mdio_master #(.DIV_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .div_half(div_half),
    .req_valid(req_valid), .req_ready(req_ready), .req_read(req_read),
    .req_short_pre(req_short_pre), .req_phy(req_phy), .req_reg(req_reg),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  assign mdio_i = mdio_oe ? 1'b0 : (phy_en ? phy_bit : 1'b1);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [15:0] phy_val(input logic [4:0] p, input logic [4:0] r);
    return 16'hA5C3 ^ {p, r, ~p, 1'b1};
  endfunction

  function automatic int eff_div(input logic [7:0] d);
    return (d < 8'd2) ? 2 : int'(d);
  endfunction

  function automatic logic [15:0] exp_header(input bit rd, input logic [4:0] p,
                                             input logic [4:0] r);
    return {2'b01, (rd ? 2'b10 : 2'b01), p, r, 2'b10};
  endfunction

  always @(posedge mdc) begin
    if (cur_read && (seen - cur_pre) >= 14 && mdio_oe) oe_bad++;
    cap  = {cap[62:0], mdio_i};
    seen = seen + 1;
  end

  always @(negedge mdc) begin
    int f;
    f = seen - cur_pre;
    if (cur_read && f >= 15 && f <= 31) begin
      phy_en  = 1'b1;
      phy_bit = (f == 15) ? 1'b0 : cur_val[31 - f];
    end else begin
      phy_en  = 1'b0;
      phy_bit = 1'b1;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (mdio_o) mdo_bad++;
      if (mdio_oe != prev_oe && mdc) oe_hi_bad++;
    end
    prev_oe = mdio_oe;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic run_txn(input bit rd, input logic [4:0] p, input logic [4:0] r,
                         input logic [15:0] wd, input bit sp, input logic [7:0] dv,
                         input bit poke);
    int n;
    int busy_acc;
    int pre;
    int lat;
    logic [15:0] data_exp;
    @(negedge clk);
    pre      = sp ? 1 : 32;
    cur_read = rd;
    cur_pre  = pre;
    cur_val  = phy_val(p, r);
    seen     = 0;
    cap      = '0;
    oe_bad   = 0;
    busy_acc = 0;
    div_half      = dv;
    req_read      = rd;
    req_phy       = p;
    req_reg       = r;
    req_wdata     = wd;
    req_short_pre = sp;
    req_valid     = 1'b1;
    check(req_ready == 1'b1, "R1", "ready when idle", req_ready, 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    div_half  = 8'd7;
    check(req_ready == 1'b0, "R1", "ready after accept", req_ready, 0);
    n = 0;
    while (!rsp_valid && n < 20000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (poke && n == 5) begin
        req_valid     = 1'b1;
        req_read      = ~rd;
        req_phy       = ~p;
        req_reg       = ~r;
        req_wdata     = ~wd;
        req_short_pre = ~sp;
      end
      if (req_valid && req_ready && !rsp_valid) busy_acc++;
    end
    req_valid = 1'b0;
    lat = 2 * eff_div(dv) * (pre + 32);
    check(n == lat, "R2", "response latency", n, lat);
    check(seen == pre + 32, "R3", "mdc rising edges", seen, pre + 32);
    if (sp)
      check(cap[63:32] == 32'h0000_0001, "R3", "short preamble", cap[63:32], 1);
    else
      check(cap[63:32] == 32'hFFFF_FFFF, "R3", "long preamble", cap[63:32], 32'hFFFFFFFF);
    check(cap[31:16] == exp_header(rd, p, r), "R4", "header bits",
          cap[31:16], exp_header(rd, p, r));
    data_exp = rd ? phy_val(p, r) : wd;
    if (rd) begin
      check(cap[15:0] == data_exp, "R6", "read line data", cap[15:0], data_exp);
      check(rsp_rdata == data_exp, "R6", "rsp_rdata", rsp_rdata, data_exp);
      check(oe_bad == 0, "R6", "driven during release", oe_bad, 0);
    end else begin
      check(cap[15:0] == data_exp, "R5", "write line data", cap[15:0], data_exp);
      check(rsp_rdata == 16'h0, "R6", "write rsp_rdata", rsp_rdata, 0);
    end
    if (poke) check(busy_acc == 0, "R9", "accept while busy", busy_acc, 0);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R8", "rsp pulse width", rsp_valid, 0);
    check(req_ready && !mdc, "R2", "idle with mdc low", {req_ready, mdc}, 2'b10);
    check(mdo_bad == 0 && oe_hi_bad == 0, "R7", "pin rules",
          mdo_bad + oe_hi_bad, 0);
    cur_read = 0;
  endtask

  initial begin
    void'($urandom(32'd20250110));
    rst_n = 1'b0; req_valid = 1'b0; req_read = 1'b0; req_short_pre = 1'b0;
    req_phy = '0; req_reg = '0; req_wdata = '0; div_half = 8'd2;
    cur_read = 0; cur_pre = 32; cur_val = '0; seen = 0; cap = '0;
    oe_bad = 0; mdo_bad = 0; oe_hi_bad = 0; phy_en = 0; phy_bit = 1; prev_oe = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(mdc == 1'b0, "R2", "reset mdc", mdc, 0);
    check(mdio_oe == 1'b0, "R7", "reset oe", mdio_oe, 0);
    check(rsp_valid == 1'b0, "R8", "reset rsp_valid", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    check(mdio_o == 1'b0, "R7", "mdio_o after reset", mdio_o, 0);

    run_txn(0, 5'd0,  5'd0,  16'hFFFF, 0, 8'd2, 0);
    run_txn(1, 5'd31, 5'd31, 16'h0000, 0, 8'd3, 0);
    run_txn(1, 5'd3,  5'd17, 16'h0000, 1, 8'd2, 0);
    run_txn(0, 5'd9,  5'd2,  16'h0000, 1, 8'd4, 0);
    run_txn(0, 5'd21, 5'd10, 16'h8001, 0, 8'd0, 0);
    run_txn(1, 5'd1,  5'd30, 16'h1234, 1, 8'd1, 1);
    run_txn(0, 5'd16, 5'd5,  16'hC3A5, 0, 8'd2, 1);
    for (int i = 0; i < 16; i++) begin
      run_txn(1'($urandom_range(0, 1)), 5'($urandom_range(0, 31)),
              5'($urandom_range(0, 31)), 16'($urandom_range(0, 65535)),
              1'($urandom_range(0, 1)), 8'($urandom_range(0, 5)),
              1'($urandom_range(0, 1)));
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule